// File: doc/BRIEF.md
# Dual-Processor Mailbox Register File

This block holds a bank of sixteen 8-bit registers that a host processor and an embedded microcontroller share to exchange commands and parameters. The host reaches the bank indirectly. It first writes a register number into an index register and then reads or writes the selected register through a data port. The microcontroller addresses all sixteen registers directly.

Two registers act as command mailboxes, and each one has a single owner. Register 0 carries commands from the host to the microcontroller. Register 1 carries commands the other way. When the owner writes its mailbox, the block stores the byte and raises a sticky pending flag that interrupts the peer. When the peer writes that same mailbox, the block discards the byte, zeroes the register and clears the flag. This zeroing write is how the peer reports that the command is done.

Each pending flag is a two-state machine with the states CH_IDLE and CH_PEND. The RAISE transition goes from CH_IDLE to CH_PEND on an owner write. The ACK transition goes from CH_PEND back to CH_IDLE on a clearing write from the peer. In every other case the machine holds its state. Each interrupt output is gated by a mask bit that belongs to the receiving side. The other fourteen registers are plain storage that both sides can read and write.

Top module: `mbox_bank`

## Requirements
- R1: Reset sets all sixteen registers to 0x00 and the host index to 0. It also sets both mask bits (1 = masked), so `mc_irq` and `host_irq` are low.
- R2: When `host_idx_we` is high, the block stores only bits [3:0] of `host_wdata` as the index and ignores bits [7:4]. `host_rdata` shows the register the index selects, combinationally, and a `host_dat_we` write goes to that register.
- R3: `mc_rdata` shows register `mc_addr` combinationally. When `mc_we` is high, the block writes `mc_wdata` into register `mc_addr`.
- R4: Registers 2 to 15 take data from whichever side writes them. A write to one register leaves every other register unchanged.
- R5: A host write to register 0 stores the byte. A microcontroller write to register 0 ignores its byte and sets the register to 0x00.
- R6: A microcontroller write to register 1 stores the byte. A host write to register 1 ignores its byte and sets the register to 0x00.
- R7: An owner write to a mailbox takes its pending flag to CH_PEND (RAISE). The peer's clearing write takes the flag back to CH_IDLE (ACK). The flag holds its state through all other accesses.
- R8: `mc_irq` is high when the host-to-microcontroller flag is pending and the microcontroller mask is 0. `host_irq` is high when the microcontroller-to-host flag is pending and the host mask is 0. `mc_mask_we` loads `mc_mask_d`, and `host_mask_we` loads `host_mask_d`. Setting a mask never clears a pending flag.
- R9: When both sides write the same register in the same cycle, the host write wins:
  - A general register takes the host byte.
  - Register 0 takes the host byte and its flag is raised.
  - Register 1 becomes 0x00 and its flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_idx_we | input | 1 | Host writes the index register |
| host_dat_we | input | 1 | Host writes the register selected by the index |
| host_wdata | input | 8 | Host write data, used for both index and data writes |
| host_rdata | output | 8 | The register selected by the index |
| host_mask_we | input | 1 | Host loads its interrupt mask bit |
| host_mask_d | input | 1 | New host mask value (1 = masked) |
| host_irq | output | 1 | Interrupt to the host, raised by the microcontroller-to-host mailbox |
| mc_we | input | 1 | Microcontroller write strobe |
| mc_addr | input | 4 | Microcontroller register address |
| mc_wdata | input | 8 | Microcontroller write data |
| mc_rdata | output | 8 | Register selected by `mc_addr` |
| mc_mask_we | input | 1 | Microcontroller loads its interrupt mask bit |
| mc_mask_d | input | 1 | New microcontroller mask value (1 = masked) |
| mc_irq | output | 1 | Interrupt to the microcontroller, raised by the host-to-microcontroller mailbox |

## Verification
The bench builds the block with its default parameters: sixteen 8-bit registers, with the mailboxes at indices 0 and 1. At these values the index truncation, the two mailbox addresses and the top general register (15) can all be reached directly. The bench also drives collisions in the same cycle on a general register and on both mailboxes. In each collision the host priority decides both the stored byte and whether a flag is raised or cleared.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } chan_state_e;
endpackage

// File: rtl/mbox_index_reg.sv
`timescale 1ns/1ps
module mbox_index_reg #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] sel_d,
    output logic [ADDR_W-1:0] sel_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (load)
            sel_q <= sel_d;
    end
endmodule

// File: rtl/mbox_regfile.sv
`timescale 1ns/1ps
module mbox_regfile #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = $clog2(NUM_REGS),
    parameter int H2M_IDX  = 0,
    parameter int M2H_IDX  = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             host_we,
    input  logic [ADDR_W-1:0]                host_sel,
    input  logic [DATA_W-1:0]                host_wdata,
    input  logic                             mc_we,
    input  logic [ADDR_W-1:0]                mc_sel,
    input  logic [DATA_W-1:0]                mc_wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  bank_q
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        logic host_hit;
        logic mc_hit;
        assign host_hit = host_we && (host_sel == ADDR_W'(g));
        assign mc_hit   = mc_we   && (mc_sel   == ADDR_W'(g));

        if (g == H2M_IDX) begin : g_h2m
            // host owns it; a microcontroller write zeroes it
            always_ff @(posedge clk) begin
                if (!rst_n)        bank_q[g] <= '0;
                else if (host_hit) bank_q[g] <= host_wdata;
                else if (mc_hit)   bank_q[g] <= '0;
            end
        end else if (g == M2H_IDX) begin : g_m2h
            // microcontroller owns it; a host write zeroes it (host wins)
            always_ff @(posedge clk) begin
                if (!rst_n)        bank_q[g] <= '0;
                else if (host_hit) bank_q[g] <= '0;
                else if (mc_hit)   bank_q[g] <= mc_wdata;
            end
        end else begin : g_gp
            always_ff @(posedge clk) begin
                if (!rst_n)        bank_q[g] <= '0;
                else if (host_hit) bank_q[g] <= host_wdata;
                else if (mc_hit)   bank_q[g] <= mc_wdata;
            end
        end
    end
endmodule

// File: rtl/mbox_irq_chan.sv
`timescale 1ns/1ps
module mbox_irq_chan
    import mbox_pkg::*;
#(
    parameter bit OWNER_IS_HOST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_hit,
    input  logic mc_hit,
    input  logic mask_we,
    input  logic mask_d,
    output logic mask_q,
    output logic irq_o
);
    chan_state_e state_q, state_d;
    logic raise, ack;

    if (OWNER_IS_HOST) begin : g_host_owner
        assign raise = host_hit;
        assign ack   = mc_hit && !host_hit;
    end else begin : g_mc_owner
        assign raise = mc_hit && !host_hit;
        assign ack   = host_hit;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (raise) state_d = CH_PEND;
            CH_PEND: if (ack)   state_d = CH_IDLE;
            default:            state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            mask_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (mask_we) mask_q <= mask_d;
        end
    end

    always_comb begin
        unique case (state_q)
            CH_PEND: irq_o = !mask_q;
            default: irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/mbox_bank.sv
`timescale 1ns/1ps
module mbox_bank #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int H2M_IDX  = 0,
    parameter int M2H_IDX  = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_idx_we,
    input  logic                          host_dat_we,
    input  logic [DATA_W-1:0]             host_wdata,
    output logic [DATA_W-1:0]             host_rdata,
    input  logic                          host_mask_we,
    input  logic                          host_mask_d,
    output logic                          host_irq,
    input  logic                          mc_we,
    input  logic [$clog2(NUM_REGS)-1:0]   mc_addr,
    input  logic [DATA_W-1:0]             mc_wdata,
    output logic [DATA_W-1:0]             mc_rdata,
    input  logic                          mc_mask_we,
    input  logic                          mc_mask_d,
    output logic                          mc_irq
);
    localparam int ADDR_W = $clog2(NUM_REGS);

    logic [ADDR_W-1:0]               idx_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;
    logic                            mc_mask_q, host_mask_q;
    logic                            h2m_host_hit, h2m_mc_hit;
    logic                            m2h_host_hit, m2h_mc_hit;

    mbox_index_reg #(.ADDR_W(ADDR_W)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (host_idx_we),
        .sel_d (host_wdata[ADDR_W-1:0]),
        .sel_q (idx_q)
    );

    mbox_regfile #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
        .H2M_IDX(H2M_IDX), .M2H_IDX(M2H_IDX)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_dat_we),
        .host_sel   (idx_q),
        .host_wdata (host_wdata),
        .mc_we      (mc_we),
        .mc_sel     (mc_addr),
        .mc_wdata   (mc_wdata),
        .bank_q     (bank_q)
    );

    assign h2m_host_hit = host_dat_we && (idx_q   == ADDR_W'(H2M_IDX));
    assign h2m_mc_hit   = mc_we       && (mc_addr == ADDR_W'(H2M_IDX));
    assign m2h_host_hit = host_dat_we && (idx_q   == ADDR_W'(M2H_IDX));
    assign m2h_mc_hit   = mc_we       && (mc_addr == ADDR_W'(M2H_IDX));

    mbox_irq_chan #(.OWNER_IS_HOST(1'b1)) u_h2m_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_hit (h2m_host_hit),
        .mc_hit   (h2m_mc_hit),
        .mask_we  (mc_mask_we),
        .mask_d   (mc_mask_d),
        .mask_q   (mc_mask_q),
        .irq_o    (mc_irq)
    );

    mbox_irq_chan #(.OWNER_IS_HOST(1'b0)) u_m2h_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_hit (m2h_host_hit),
        .mc_hit   (m2h_mc_hit),
        .mask_we  (host_mask_we),
        .mask_d   (host_mask_d),
        .mask_q   (host_mask_q),
        .irq_o    (host_irq)
    );

    assign host_rdata = bank_q[idx_q];
    assign mc_rdata   = bank_q[mc_addr];
endmodule

// File: rtl/mbox_bank_chk.sv
`timescale 1ns/1ps
module mbox_bank_chk #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 4,
    parameter int H2M_IDX  = 0,
    parameter int M2H_IDX  = 1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             host_idx_we,
    input logic                             host_dat_we,
    input logic [DATA_W-1:0]                host_wdata,
    input logic                             mc_we,
    input logic [ADDR_W-1:0]                mc_addr,
    input logic [DATA_W-1:0]                mc_wdata,
    input logic [ADDR_W-1:0]                idx_q,
    input logic [NUM_REGS-1:0][DATA_W-1:0]  bank_q,
    input logic                             mc_mask_q,
    input logic                             host_mask_q,
    input logic                             mc_irq,
    input logic                             host_irq
);
    logic h_h2m, m_h2m, h_m2h, m_m2h;
    assign h_h2m = host_dat_we && (idx_q   == ADDR_W'(H2M_IDX));
    assign m_h2m = mc_we       && (mc_addr == ADDR_W'(H2M_IDX));
    assign h_m2h = host_dat_we && (idx_q   == ADDR_W'(M2H_IDX));
    assign m_m2h = mc_we       && (mc_addr == ADDR_W'(M2H_IDX));

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        host_idx_we |=> idx_q == $past(host_wdata[ADDR_W-1:0])); // R2

    AST_H2M_OWNER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        h_h2m |=> bank_q[H2M_IDX] == $past(host_wdata)); // R5

    AST_H2M_PEER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (m_h2m && !h_h2m) |=> bank_q[H2M_IDX] == '0); // R5

    AST_M2H_OWNER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_m2h && !h_m2h) |=> bank_q[M2H_IDX] == $past(mc_wdata)); // R6

    AST_M2H_PEER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        h_m2h |=> bank_q[M2H_IDX] == '0); // R6

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_dat_we && !mc_we) |=> $stable(bank_q)); // R4

    AST_MC_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        mc_irq |-> !mc_mask_q); // R8

    AST_HOST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> !host_mask_q); // R8

    AST_H2M_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (h_h2m && !mc_mask_q && !$past(1'b0) && !host_idx_we) |=> (mc_irq || $past(mc_mask_q) != mc_mask_q)); // R7

    AST_M2H_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        h_m2h |=> !host_irq); // R9
endmodule

bind mbox_bank mbox_bank_chk #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W),
    .H2M_IDX(H2M_IDX), .M2H_IDX(M2H_IDX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_idx_we (host_idx_we),
    .host_dat_we (host_dat_we),
    .host_wdata  (host_wdata),
    .mc_we       (mc_we),
    .mc_addr     (mc_addr),
    .mc_wdata    (mc_wdata),
    .idx_q       (idx_q),
    .bank_q      (bank_q),
    .mc_mask_q   (mc_mask_q),
    .host_mask_q (host_mask_q),
    .mc_irq      (mc_irq),
    .host_irq    (host_irq)
);

// File: tb/mbox_bank_tb.sv
`timescale 1ns/1ps
module mbox_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_idx_we = 1'b0, host_dat_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_mask_we = 1'b0, host_mask_d = 1'b1;
    logic       host_irq;
    logic       mc_we = 1'b0;
    logic [3:0] mc_addr = '0;
    logic [7:0] mc_wdata = '0;
    logic [7:0] mc_rdata;
    logic       mc_mask_we = 1'b0, mc_mask_d = 1'b1;
    logic       mc_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mbox_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_idx_we(host_idx_we), .host_dat_we(host_dat_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_mask_we(host_mask_we), .host_mask_d(host_mask_d),
        .host_irq(host_irq),
        .mc_we(mc_we), .mc_addr(mc_addr), .mc_wdata(mc_wdata),
        .mc_rdata(mc_rdata),
        .mc_mask_we(mc_mask_we), .mc_mask_d(mc_mask_d), .mc_irq(mc_irq)
    );

    // {side(0 host,1 mc), addr[3:0], data[7:0], chk_addr[3:0], expect[7:0]}
    localparam logic [24:0] VEC [10] = '{
        {1'b0, 4'd5,  8'hA5, 4'd5,  8'hA5},  // R4 host general
        {1'b1, 4'd9,  8'h3C, 4'd9,  8'h3C},  // R3 mc direct write
        {1'b0, 4'd0,  8'h11, 4'd0,  8'h11},  // R5 host owns reg0
        {1'b1, 4'd0,  8'hFF, 4'd0,  8'h00},  // R5 mc zeroes reg0
        {1'b1, 4'd1,  8'h22, 4'd1,  8'h22},  // R6 mc owns reg1
        {1'b0, 4'd1,  8'h77, 4'd1,  8'h00},  // R6 host zeroes reg1
        {1'b0, 4'd15, 8'h80, 4'd15, 8'h80},  // R4 top register
        {1'b1, 4'd15, 8'h01, 4'd15, 8'h01},  // R4 overwrite from mc
        {1'b0, 4'd2,  8'h0F, 4'd5,  8'hA5},  // R4 neighbour untouched
        {1'b1, 4'd3,  8'hEE, 4'd9,  8'h3C}   // R4 neighbour untouched
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic host_write(input logic [7:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_idx_we = 1'b1; host_wdata = sel;
        @(negedge clk);
        host_idx_we = 1'b0; host_dat_we = 1'b1; host_wdata = d;
        @(negedge clk);
        host_dat_we = 1'b0;
    endtask

    task automatic mc_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        mc_we = 1'b1; mc_addr = a; mc_wdata = d;
        @(negedge clk);
        mc_we = 1'b0;
    endtask

    task automatic set_masks(input logic mc_m, input logic host_m);
        @(negedge clk);
        mc_mask_we = 1'b1; mc_mask_d = mc_m;
        host_mask_we = 1'b1; host_mask_d = host_m;
        @(negedge clk);
        mc_mask_we = 1'b0; host_mask_we = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        #1;
        check("R1 host_rdata", host_rdata, 8'h00);
        check("R1 mc_irq", {7'b0, mc_irq}, 8'h00);
        check("R1 host_irq", {7'b0, host_irq}, 8'h00);
        for (int i = 0; i < 16; i++) begin
            mc_addr = 4'(i);
            #0.1;
            check("R1 reg", mc_rdata, 8'h00);
        end

        // table walk
        for (int v = 0; v < 10; v++) begin
            if (VEC[v][24]) mc_write(VEC[v][23:20], VEC[v][19:12]);
            else            host_write({4'h0, VEC[v][23:20]}, VEC[v][19:12]);
            mc_addr = VEC[v][11:8];
            #1;
            check("R3/R4/R5/R6 table", mc_rdata, VEC[v][7:0]);
        end

        // R2: upper index bits ignored, combinational data-port read
        @(negedge clk);
        host_idx_we = 1'b1; host_wdata = 8'hF9;
        @(negedge clk);
        host_idx_we = 1'b0;
        #1;
        check("R2 read via index 9", host_rdata, 8'h3C);
        host_write(8'hF3, 8'h5A);
        mc_addr = 4'd3;
        #1;
        check("R2 data write to index 3", mc_rdata, 8'h5A);
        check("R2 host readback", host_rdata, 8'h5A);

        // R7/R8 host-to-mc channel
        do_reset();
        host_write(8'h00, 8'h42);
        #1;
        check("R8 masked mc_irq", {7'b0, mc_irq}, 8'h00);
        set_masks(1'b0, 1'b0);
        #1;
        check("R7 pending kept under mask", {7'b0, mc_irq}, 8'h01);
        host_write(8'h05, 8'h10);
        #1;
        check("R7 sticky on other access", {7'b0, mc_irq}, 8'h01);
        set_masks(1'b1, 1'b0);
        #1;
        check("R8 remask hides", {7'b0, mc_irq}, 8'h00);
        set_masks(1'b0, 1'b0);
        #1;
        check("R8 unmask shows again", {7'b0, mc_irq}, 8'h01);
        mc_write(4'd0, 8'h99);
        #1;
        check("R7 ack clears mc_irq", {7'b0, mc_irq}, 8'h00);

        // R7/R8 mc-to-host channel
        mc_write(4'd1, 8'h24);
        #1;
        check("R7 raise host_irq", {7'b0, host_irq}, 8'h01);
        check("R8 mc_irq stays low", {7'b0, mc_irq}, 8'h00);
        host_write(8'h01, 8'hAB);
        #1;
        check("R7 host ack clears host_irq", {7'b0, host_irq}, 8'h00);

        // R9 collisions
        do_reset();
        set_masks(1'b0, 1'b0);
        @(negedge clk);
        host_idx_we = 1'b1; host_wdata = 8'h04;
        @(negedge clk);
        host_idx_we = 1'b0; host_dat_we = 1'b1; host_wdata = 8'hAA;
        mc_we = 1'b1; mc_addr = 4'd4; mc_wdata = 8'h55;
        @(negedge clk);
        host_dat_we = 1'b0; mc_we = 1'b0;
        #1;
        check("R9 general collision", mc_rdata, 8'hAA);

        @(negedge clk);
        host_idx_we = 1'b1; host_wdata = 8'h00;
        @(negedge clk);
        host_idx_we = 1'b0; host_dat_we = 1'b1; host_wdata = 8'h33;
        mc_we = 1'b1; mc_addr = 4'd0; mc_wdata = 8'hFF;
        @(negedge clk);
        host_dat_we = 1'b0; mc_we = 1'b0;
        #1;
        check("R9 reg0 collision data", mc_rdata, 8'h33);
        check("R9 reg0 collision irq", {7'b0, mc_irq}, 8'h01);

        mc_write(4'd1, 8'h44);
        @(negedge clk);
        host_idx_we = 1'b1; host_wdata = 8'h01;
        @(negedge clk);
        host_idx_we = 1'b0; host_dat_we = 1'b1; host_wdata = 8'h99;
        mc_we = 1'b1; mc_addr = 4'd1; mc_wdata = 8'h66;
        @(negedge clk);
        host_dat_we = 1'b0; mc_we = 1'b0;
        #1;
        check("R9 reg1 collision data", mc_rdata, 8'h00);
        check("R9 reg1 collision irq", {7'b0, host_irq}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule